// File: doc/BRIEF.md
# Serial Configuration Sync Receiver

This block is the target side of a bit-serial configuration port. A host sends a serial clock and a data line. On every rising edge of the serial clock the receiver takes one data bit. The serial clock may be slow, irregular or paused for any length of time. Before anything counts, the receiver hunts for a fixed 32-bit synchronisation pattern. Any bits ahead of that pattern are discarded, including 0xFF padding and patterns that would otherwise look like errors. Once the pattern is found, the bits that follow are packed into 32-bit words, most significant bit first. Each word comes out with a one-cycle strobe.

After synchronisation, the receiver watches the word stream for an identification header word. It checks the word that follows the header against an expected device identifier, leaving out the top nibble. A mismatch pulls the active-low init/error indication low. After a set number of clean words the done indication rises and stays high.

An active-low program pulse returns the receiver to the hunting state. While the pulse is low, the init/error indication is also held low. All inputs from the host are resynchronised into the system clock domain before use.

Top module: `cfgsync_rx`

## Requirements
- R1: A data bit is taken only on a rising edge of `cclk_i`. Any low or high time of the serial clock, including long stalls, gives the same result.
- R2: While hunting, `synced_o` stays low and no word is emitted. `synced_o` rises once the most recent 32 bits, oldest first, equal `SYNC_WORD` (default 0xAA995566). Leading 0xFF padding and near-miss patterns do not cause synchronisation.
- R3: Before synchronisation no data pattern drives `init_n_o` low. This includes an identification header followed by a wrong identifier.
- R4: After synchronisation, each group of 32 following bits is emitted on `word_o`, with the first received bit in bit 31. `word_vld_o` is high for exactly one clock per word. The sync pattern itself is never emitted.
- R5: A word that immediately follows a word equal to `ID_HDR` (default 0x30018001) is compared with `EXP_ID` (default 0x0400E093) on bits 27..0 only. On a mismatch `init_n_o` goes low and stays low until a program pulse.
- R6: A word not directly preceded by the header word is never compared. Identifier-like values elsewhere leave `init_n_o` high.
- R7: `done_o` rises once `DONE_WORDS` post-sync words (header and identifier included) have arrived with no error. It then stays high through further words.
- R8: `done_o` and the error are never high together. An error holds `done_o` low.
- R9: While `prog_n_i` is low, `init_n_o` is low. After the pulse the receiver is hunting again, with `synced_o`, `done_o` and the error cleared.
- R10: `synced_o` stays high from synchronisation until the next program pulse or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cclk_i | input | 1 | Serial configuration clock from host |
| din_i | input | 1 | Serial configuration data |
| prog_n_i | input | 1 | Active-low program pulse, restarts the receiver |
| word_o | output | 32 | Last assembled post-sync word |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` |
| synced_o | output | 1 | Sync pattern has been found |
| init_n_o | output | 1 | Active-low init/error indication |
| done_o | output | 1 | Stream completed without error |

## Verification
The bench builds the receiver with `DONE_WORDS` = 6 and keeps the default sync pattern, header and identifier. With this setting the done threshold is reached within a short stream. This lets the bench check the off-by-one boundary: `done_o` is low after five words and high after six. Two resynchronisation stages are kept. The serial clock is driven with changing and occasionally long low times, so the edge-only sampling is exercised against stalls. Streams with a wrong identifier, identifier-like values without a header, and bad patterns before sync cover the gating of the error indication.

// File: rtl/cfgsync_pkg.sv
package cfgsync_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  // identifier compare leaves out the top nibble
  localparam word_t ID_MASK = {4'h0, {(WORD_W-4){1'b1}}};
endpackage

// File: rtl/cfgsync_edge.sv
module cfgsync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cclk_i,
  input  logic din_i,
  input  logic prog_n_i,
  output logic bit_vld,
  output logic bit_d,
  output logic clr
);
  logic [STAGES-1:0] c_s, d_s, p_s;
  logic              c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_s     <= '0;
      d_s     <= '0;
      p_s     <= '1;
      c_q     <= 1'b0;
      bit_vld <= 1'b0;
      bit_d   <= 1'b0;
    end else begin
      c_s     <= {c_s[STAGES-2:0], cclk_i};
      d_s     <= {d_s[STAGES-2:0], din_i};
      p_s     <= {p_s[STAGES-2:0], prog_n_i};
      c_q     <= c_s[STAGES-1];
      // one strobe per low-to-high transition, suppressed while programming
      bit_vld <= c_s[STAGES-1] & ~c_q & p_s[STAGES-1];
      bit_d   <= d_s[STAGES-1];
    end
  end

  assign clr = ~p_s[STAGES-1];

  // strobes come from transitions, so never on back-to-back cycles (R1)
  p_bit_single_r1: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);
endmodule

// File: rtl/cfgsync_asm.sv
module cfgsync_asm
  import cfgsync_pkg::*;
#(
  parameter word_t SYNC_WORD = 32'hAA99_5566
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  bit_vld,
  input  logic  bit_d,
  output logic  synced,
  output word_t word,
  output logic  word_vld
);
  localparam int unsigned CW = $clog2(WORD_W);

  word_t         sh;
  word_t         sh_nxt;
  logic [CW-1:0] cnt;

  assign sh_nxt = {sh[WORD_W-2:0], bit_d};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh       <= '0;
      synced   <= 1'b0;
      cnt      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (bit_vld) begin
        sh <= sh_nxt;
        if (!synced) begin
          if (sh_nxt == SYNC_WORD) begin
            synced <= 1'b1;
            cnt    <= '0;
          end
        end else begin
          if (cnt == CW'(WORD_W-1)) begin
            cnt      <= '0;
            word     <= sh_nxt;
            word_vld <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  p_word_from_bit_r1: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_vld));
  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
  p_synced_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (synced && !clr) |=> synced);
endmodule

// File: rtl/cfgsync_chk.sv
module cfgsync_chk
  import cfgsync_pkg::*;
#(
  parameter word_t       ID_HDR     = 32'h3001_8001,
  parameter word_t       EXP_ID     = 32'h0400_E093,
  parameter int unsigned DONE_WORDS = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  synced,
  input  word_t word,
  input  logic  word_vld,
  output logic  err,
  output logic  done
);
  localparam int unsigned NW = $clog2(DONE_WORDS + 1);

  logic          hdr_seen;
  logic [NW-1:0] wcnt;
  logic          id_bad;
  logic          err_set;

  assign id_bad  = ((word ^ EXP_ID) & ID_MASK) != '0;
  assign err_set = word_vld & hdr_seen & id_bad;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hdr_seen <= 1'b0;
      wcnt     <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
    end else if (word_vld) begin
      hdr_seen <= (word == ID_HDR);
      if (wcnt != NW'(DONE_WORDS)) wcnt <= wcnt + 1'b1;
      err <= err | err_set;
      if (err || err_set)                    done <= 1'b0;
      else if (wcnt == NW'(DONE_WORDS - 1)) done <= 1'b1;
    end
  end

  p_no_err_unsynced_r3: assert property (@(posedge clk) disable iff (rst)
    !synced |-> !err);
  p_done_excl_err_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !clr && !err_set) |=> done);
endmodule

// File: rtl/cfgsync_rx.sv
module cfgsync_rx
  import cfgsync_pkg::*;
#(
  parameter logic [31:0] SYNC_WORD   = 32'hAA99_5566,
  parameter logic [31:0] ID_HDR      = 32'h3001_8001,
  parameter logic [31:0] EXP_ID      = 32'h0400_E093,
  parameter int unsigned DONE_WORDS  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cclk_i,
  input  logic        din_i,
  input  logic        prog_n_i,
  output logic [31:0] word_o,
  output logic        word_vld_o,
  output logic        synced_o,
  output logic        init_n_o,
  output logic        done_o
);
  logic  bit_vld, bit_d, clr, synced, word_vld, err, done;
  word_t word;

  cfgsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .cclk_i(cclk_i), .din_i(din_i), .prog_n_i(prog_n_i),
    .bit_vld(bit_vld), .bit_d(bit_d), .clr(clr)
  );

  cfgsync_asm #(.SYNC_WORD(SYNC_WORD)) u_asm (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_d(bit_d),
    .synced(synced), .word(word), .word_vld(word_vld)
  );

  cfgsync_chk #(.ID_HDR(ID_HDR), .EXP_ID(EXP_ID), .DONE_WORDS(DONE_WORDS)) u_chk (
    .clk(clk), .rst(rst), .clr(clr), .synced(synced), .word(word),
    .word_vld(word_vld), .err(err), .done(done)
  );

  assign word_o     = word;
  assign word_vld_o = word_vld;
  assign synced_o   = synced;
  assign done_o     = done;
  assign init_n_o   = ~(err | clr);

  // programming holds the error indication low (R9)
  p_init_low_prog_r9: assert property (@(posedge clk) disable iff (rst)
    clr |-> !init_n_o);
endmodule

// File: tb/tb_cfgsync_rx.sv
module tb_cfgsync_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cclk = 1'b0, din = 1'b0, prog_n = 1'b1;
  logic [31:0] word_o;
  logic        word_vld_o, synced_o, init_n_o, done_o;

  int errors = 0, checks = 0, bitn = 0;
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  cfgsync_rx #(.DONE_WORDS(6), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cclk_i(cclk), .din_i(din), .prog_n_i(prog_n),
    .word_o(word_o), .word_vld_o(word_vld_o), .synced_o(synced_o),
    .init_n_o(init_n_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: each strobe pops one expected word (R4, R1)
  always @(negedge clk) begin
    if (!rst && word_vld_o) begin
      if (expq.size() == 0) chk("R2/R4 unexpected word", word_o, 32'hxxxx_xxxx);
      else chk("R4 word", word_o, expq.pop_front());
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // low time varies, with an occasional long stall (R1)
  task automatic send_bit(input logic b);
    @(negedge clk);
    cclk = 1'b0; din = b;
    waitc(2 + (bitn % 4) + ((bitn % 37 == 5) ? 40 : 0));
    cclk = 1'b1;
    waitc(3 + (bitn % 3));
    bitn++;
  endtask

  task automatic send_word(input logic [31:0] w, input bit push);
    if (push) expq.push_back(w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pad();
    send_word(32'hFFFF_FFFF, 1'b0);
    send_word(32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic prog_pulse();
    @(negedge clk); prog_n = 1'b0;
    waitc(6);
    chk("R9 init low during program", {31'd0, init_n_o}, 32'd0);
    prog_n = 1'b1;
    waitc(8);
    expq.delete();
  endtask

  initial begin
    waitc(4);
    rst = 1'b0;
    waitc(4);
    chk("reset init_n", {31'd0, init_n_o}, 32'd1);
    chk("reset done", {31'd0, done_o}, 32'd0);
    chk("reset synced", {31'd0, synced_o}, 32'd0);

    // pre-sync garbage, including a bad identifier after the header
    pad();
    send_word(32'h3001_8001, 1'b0);
    send_word(32'h0400_E094, 1'b0);
    send_word(32'hAA99_5567, 1'b0);
    send_word(32'h5599_AA66, 1'b0);
    waitc(10);
    chk("R2 no sync on near miss", {31'd0, synced_o}, 32'd0);
    chk("R3 init high before sync", {31'd0, init_n_o}, 32'd1);

    // good stream
    prog_pulse();
    pad();
    send_word(32'hAA99_5566, 1'b0);
    waitc(10);
    chk("R2 synced after pattern", {31'd0, synced_o}, 32'd1);
    send_word(32'h2000_0000, 1'b1);
    send_word(32'h3001_8001, 1'b1);
    send_word(32'h7400_E093, 1'b1);
    send_word(32'h1111_2222, 1'b1);
    send_word(32'hDEAD_BEEF, 1'b1);
    waitc(10);
    chk("R7 done low after five words", {31'd0, done_o}, 32'd0);
    send_word(32'h0000_0000, 1'b1);
    waitc(10);
    chk("R7 done after six words", {31'd0, done_o}, 32'd1);
    chk("R5 top nibble ignored", {31'd0, init_n_o}, 32'd1);
    send_word(32'hA5A5_A5A5, 1'b1);
    waitc(10);
    chk("R7 done sticky", {31'd0, done_o}, 32'd1);
    chk("R10 synced held", {31'd0, synced_o}, 32'd1);
    chk("R4 queue drained", expq.size(), 32'd0);

    // bad identifier
    prog_pulse();
    chk("R9 done cleared", {31'd0, done_o}, 32'd0);
    chk("R9 synced cleared", {31'd0, synced_o}, 32'd0);
    pad();
    send_word(32'hAA99_5566, 1'b0);
    send_word(32'h3001_8001, 1'b1);
    send_word(32'h0400_E094, 1'b1);
    waitc(10);
    chk("R5 init low on mismatch", {31'd0, init_n_o}, 32'd0);
    for (int k = 0; k < 5; k++) send_word(32'h0101_0000 + k, 1'b1);
    waitc(10);
    chk("R8 no done after error", {31'd0, done_o}, 32'd0);
    chk("R5 error sticky", {31'd0, init_n_o}, 32'd0);

    // identifier-like words without header
    prog_pulse();
    chk("R9 error cleared", {31'd0, init_n_o}, 32'd1);
    pad();
    send_word(32'hAA99_5566, 1'b0);
    send_word(32'h0400_E095, 1'b1);
    send_word(32'h0400_E094, 1'b1);
    waitc(10);
    chk("R6 unchecked words", {31'd0, init_n_o}, 32'd1);
    chk("R4 queue drained", expq.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule